// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the stream of transfer addresses for a single DMA channel. Software programs a small set of registers: start address, inner count and stride, outer count and stride, a configuration word and a descriptor pointer. It then pulses a start input. The block issues one address per cycle over a valid/ready handshake. It raises a one-cycle completion pulse at the end of each work unit. In circular mode it also raises a pulse at a half or quarter fill point.

Register modes cover three cases: a single linear pass, a pass that reloads and repeats on its own, and a circular buffer. Descriptor modes read their parameters through a simple memory read port. That port carries one request at a time and the response returns with a valid strobe. Three descriptor layouts are supported. A two-word ring descriptor holds a link and an address. A one-word array entry holds an address only, and the entries sit at consecutive word addresses. A four-word list descriptor holds a link, an address, a length and a configuration word. Descriptors are read only between work units. Any of these modes can walk a two-dimensional pattern.

Top module: `dma_addr_seq`

## Requirements
- R1: Register selects are 0 start, 1 inner count, 2 inner stride, 3 outer count, 4 outer stride, 5 config, 6 descriptor pointer. In the config word, bits [2:0] are the flow, bits [4:3] are the fraction and bit 5 is the 2D enable. With flow 0, a start issues start + k*stride for k = 0 to count-1. The cycle after the last handshake shows a completion pulse and busy low.
- R2: The inner stride is a two's complement value. Negative, zero and positive strides step the address by that amount, modulo 2^AW.
- R3: While the address is valid and ready is low, both the address and its valid stay unchanged. Only a cycle with a handshake advances the sequence.
- R4: With flow 1, the completed pass restarts at the programmed start address with no gap. A completion pulse is given for every pass.
- R5: With flow 2, the buffer wraps like flow 1. Fraction 1 gives a pulse after every T/2 elements and fraction 2 after every T/4 elements, where T is the element total. No fraction pulse falls on the final element. Fraction 0 gives none.
- R6: With the 2D bit set, each row has inner-count elements spaced by the inner stride. After the last element of a row, the outer stride is added to reach the next row. The unit holds inner*outer elements.
- R7: Flow 4 reads two words at pointer P and P+1: the next pointer, then the start address. Count, strides and config stay as programmed. The chain follows the next pointer without end.
- R8: Flow 5 reads one word holding a start address. The next entry is read at the following word address.
- R9: Flow 6 reads four words in the order next pointer, start, length, config. A loaded config whose flow is 6 continues the chain. Any other loaded flow ends it after that unit.
- R10: While a descriptor read is pending, the address output is not valid. No read is issued while an address is valid.
- R11: A zero count at the start of a unit, or a reserved flow value (3 or 7) at start, sets a sticky error and leaves the channel idle without issuing an address. The next start clears the error.
- R12: After reset, busy, valid, read request, both interrupt outputs and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | AW | Register write data |
| start_i | input | 1 | Starts the channel when idle |
| busy_o | output | 1 | Channel active |
| addr_o | output | AW | Transfer address |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Address accepted |
| desc_rd_o | output | 1 | Descriptor read request |
| desc_addr_o | output | AW | Descriptor word address |
| desc_rvalid_i | input | 1 | Descriptor read data valid |
| desc_rdata_i | input | AW | Descriptor read data |
| done_irq_o | output | 1 | Work unit complete pulse |
| frac_irq_o | output | 1 | Fractional fill pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
A corrupted counter or address register shows up at the next accepted address, or as a completion pulse one element too early or too late. The bench therefore compares every issued address against an arithmetic sequence and checks the interrupt pins in the cycle right after each handshake. A wrong descriptor field mapping appears in the first address of the next unit. A wrong continuation decision shows up as busy remaining high, or a read request appearing, one cycle after the final element.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam logic [2:0] FLOW_STOP  = 3'd0;
  localparam logic [2:0] FLOW_AUTO  = 3'd1;
  localparam logic [2:0] FLOW_CIRC  = 3'd2;
  localparam logic [2:0] FLOW_RING  = 3'd4;
  localparam logic [2:0] FLOW_ARRAY = 3'd5;
  localparam logic [2:0] FLOW_LIST  = 3'd6;

  localparam logic [2:0] SEL_START   = 3'd0;
  localparam logic [2:0] SEL_ICNT    = 3'd1;
  localparam logic [2:0] SEL_ISTRIDE = 3'd2;
  localparam logic [2:0] SEL_OCNT    = 3'd3;
  localparam logic [2:0] SEL_OSTRIDE = 3'd4;
  localparam logic [2:0] SEL_CFG     = 3'd5;
  localparam logic [2:0] SEL_LINK    = 3'd6;

  localparam logic [1:0] FRAC_HALF    = 2'd1;
  localparam logic [1:0] FRAC_QUARTER = 2'd2;

  typedef struct packed {
    logic       dim2;
    logic [1:0] frac;
    logic [2:0] flow;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_RUN} seq_state_e;

  function automatic logic is_chained(input logic [2:0] f);
    return (f == FLOW_RING) || (f == FLOW_ARRAY) || (f == FLOW_LIST);
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] icnt_i,
  input  logic [CW-1:0] ocnt_i,
  input  logic [AW-1:0] istride_i,
  input  logic [AW-1:0] ostride_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] irem_q, orem_q, iinit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      irem_q  <= '0;
      orem_q  <= '0;
      iinit_q <= '0;
    end else if (load_i) begin
      addr_q  <= base_i;
      irem_q  <= icnt_i;
      orem_q  <= ocnt_i;
      iinit_q <= icnt_i;
    end else if (step_i) begin
      if (irem_q == CW'(1)) begin
        // row end: outer stride from the last element
        irem_q <= iinit_q;
        orem_q <= orem_q - CW'(1);
        addr_q <= addr_q + ostride_i;
      end else begin
        irem_q <= irem_q - CW'(1);
        addr_q <= addr_q + istride_i;
      end
    end
  end

  assign addr_o = addr_q;
  assign last_o = (irem_q == CW'(1)) && (orem_q == CW'(1));
endmodule

// File: rtl/dma_frac_tap.sv
module dma_frac_tap #(
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [1:0]    mode_i,
  input  logic [TW-1:0] total_i,
  output logic          irq_o
);
  import dma_seq_pkg::*;

  logic [TW-1:0] seg_cnt_q, quota, seg_nxt;
  logic          hit, irq_q;

  always_comb begin
    unique case (mode_i)
      FRAC_HALF:    quota = total_i >> 1;
      FRAC_QUARTER: quota = total_i >> 2;
      default:      quota = '0;
    endcase
  end

  assign seg_nxt = seg_cnt_q + TW'(1);
  assign hit     = (quota != '0) && (seg_nxt == quota);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_cnt_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= step_i && hit && !last_i;
      if (clear_i)     seg_cnt_q <= '0;
      else if (step_i) seg_cnt_q <= hit ? '0 : seg_nxt;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    last_idx_i,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  input  logic          rvalid_i,
  output logic          word_v_o,
  output logic [1:0]    word_idx_o,
  output logic          done_o
);
  logic          active_q, wait_q;
  logic [1:0]    idx_q, last_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      base_q   <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      last_q   <= last_idx_i;
      base_q   <= base_i;
    end else if (active_q) begin
      if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (rvalid_i) begin
        wait_q <= 1'b0;
        if (idx_q == last_q) active_q <= 1'b0;
        else                 idx_q    <= idx_q + 2'd1;
      end
    end
  end

  assign rd_o       = active_q && !wait_q;
  assign addr_o     = base_q + AW'(idx_q);
  assign word_v_o   = active_q && wait_q && rvalid_i;
  assign word_idx_o = idx_q;
  assign done_o     = word_v_o && (idx_q == last_q);
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic          desc_rd_o,
  output logic [AW-1:0] desc_addr_o,
  input  logic          desc_rvalid_i,
  input  logic [AW-1:0] desc_rdata_i,
  output logic          done_irq_o,
  output logic          frac_irq_o,
  output logic          err_o
);
  localparam int TW = 2 * CW;

  // programmed copies
  logic [AW-1:0] p_start, p_istride, p_ostride, p_link;
  logic [CW-1:0] p_icnt, p_ocnt;
  cfg_t          p_cfg;

  // working copies
  logic [AW-1:0] w_start, w_istride, w_ostride, link_q;
  logic [CW-1:0] w_icnt, w_ocnt;
  cfg_t          w_cfg;
  logic [2:0]    chain_fmt;
  seq_state_e    state_q;
  logic          err_q, done_q;

  logic          hs, gen_last, unit_end, repeat_unit, chain_next;
  logic          load_ok, gen_load, start_ok, fetch_go;
  logic [2:0]    fmt_src;
  logic [1:0]    last_idx;
  logic [AW-1:0] fetch_base;
  logic [CW-1:0] eff_ocnt;
  logic [TW-1:0] total;
  logic [1:0]    frac_mode;
  logic          f_word_v, f_done;
  logic [1:0]    f_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_start   <= '0;
      p_icnt    <= '0;
      p_istride <= '0;
      p_ocnt    <= '0;
      p_ostride <= '0;
      p_cfg     <= '0;
      p_link    <= '0;
    end else if (reg_we_i) begin
      unique case (reg_sel_i)
        SEL_START:   p_start   <= reg_wdata_i;
        SEL_ICNT:    p_icnt    <= reg_wdata_i[CW-1:0];
        SEL_ISTRIDE: p_istride <= reg_wdata_i;
        SEL_OCNT:    p_ocnt    <= reg_wdata_i[CW-1:0];
        SEL_OSTRIDE: p_ostride <= reg_wdata_i;
        SEL_CFG:     p_cfg     <= cfg_t'(reg_wdata_i[CFG_W-1:0]);
        SEL_LINK:    p_link    <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign hs          = addr_valid_o && addr_ready_i;
  assign unit_end    = hs && gen_last;
  assign repeat_unit = unit_end && !is_chained(chain_fmt) &&
                       ((w_cfg.flow == FLOW_AUTO) || (w_cfg.flow == FLOW_CIRC));
  assign chain_next  = unit_end && is_chained(chain_fmt) &&
                       !((chain_fmt == FLOW_LIST) && (w_cfg.flow != FLOW_LIST));
  assign load_ok     = (state_q == ST_LOAD) && (w_icnt != '0) &&
                       !(w_cfg.dim2 && (w_ocnt == '0));
  assign gen_load    = load_ok || repeat_unit;
  assign start_ok    = (state_q == ST_IDLE) && start_i;
  assign fetch_go    = (start_ok && is_chained(p_cfg.flow)) || chain_next;
  assign fmt_src     = (state_q == ST_IDLE) ? p_cfg.flow : chain_fmt;
  assign fetch_base  = (state_q == ST_IDLE) ? p_link : link_q;

  always_comb begin
    unique case (fmt_src)
      FLOW_ARRAY: last_idx = 2'd0;
      FLOW_RING:  last_idx = 2'd1;
      default:    last_idx = 2'd3;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      w_start   <= '0;
      w_icnt    <= '0;
      w_istride <= '0;
      w_ocnt    <= '0;
      w_ostride <= '0;
      w_cfg     <= '0;
      link_q    <= '0;
      chain_fmt <= FLOW_STOP;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= unit_end;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          w_start   <= p_start;
          w_icnt    <= p_icnt;
          w_istride <= p_istride;
          w_ocnt    <= p_ocnt;
          w_ostride <= p_ostride;
          w_cfg     <= p_cfg;
          link_q    <= p_link;
          chain_fmt <= p_cfg.flow;
          err_q     <= 1'b0;
          if (is_chained(p_cfg.flow))
            state_q <= ST_FETCH;
          else if (p_cfg.flow inside {FLOW_STOP, FLOW_AUTO, FLOW_CIRC})
            state_q <= ST_LOAD;
          else
            err_q <= 1'b1;
        end
        ST_FETCH: begin
          if (f_word_v) begin
            if (chain_fmt == FLOW_ARRAY) begin
              w_start <= desc_rdata_i;
            end else begin
              unique case (f_idx)
                2'd0: link_q  <= desc_rdata_i;
                2'd1: w_start <= desc_rdata_i;
                2'd2: w_icnt  <= desc_rdata_i[CW-1:0];
                default: w_cfg <= cfg_t'(desc_rdata_i[CFG_W-1:0]);
              endcase
            end
          end
          if (f_done) begin
            if (chain_fmt == FLOW_ARRAY) link_q <= link_q + AW'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (load_ok) state_q <= ST_RUN;
          else begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: if (unit_end) begin
          if (chain_next)        state_q <= ST_FETCH;
          else if (!repeat_unit) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign eff_ocnt  = w_cfg.dim2 ? w_ocnt : CW'(1);
  assign total     = TW'(w_icnt) * TW'(eff_ocnt);
  assign frac_mode = (!is_chained(chain_fmt) && (w_cfg.flow == FLOW_CIRC)) ? w_cfg.frac : 2'd0;

  dma_addr_gen #(.AW(AW), .CW(CW)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gen_load),
    .base_i    (w_start),
    .icnt_i    (w_icnt),
    .ocnt_i    (eff_ocnt),
    .istride_i (w_istride),
    .ostride_i (w_ostride),
    .step_i    (hs),
    .addr_o    (addr_o),
    .last_o    (gen_last)
  );

  dma_frac_tap #(.TW(TW)) u_frac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (gen_load),
    .step_i  (hs),
    .last_i  (gen_last),
    .mode_i  (frac_mode),
    .total_i (total),
    .irq_o   (frac_irq_o)
  );

  dma_desc_fetch #(.AW(AW)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (fetch_go),
    .base_i     (fetch_base),
    .last_idx_i (last_idx),
    .rd_o       (desc_rd_o),
    .addr_o     (desc_addr_o),
    .rvalid_i   (desc_rvalid_i),
    .word_v_o   (f_word_v),
    .word_idx_o (f_idx),
    .done_o     (f_done)
  );

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i, desc_rdata_i, start_ok};

  assign busy_o       = (state_q != ST_IDLE);
  assign addr_valid_o = (state_q == ST_RUN);
  assign done_irq_o   = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic [AW-1:0] addr_o,
  input logic          addr_valid_o,
  input logic          addr_ready_i,
  input logic          desc_rd_o,
  input logic          done_irq_o,
  input logic          frac_irq_o,
  input logic          err_o
);
  // R3
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o)));

  // R10
  fetch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_rd_o |-> !addr_valid_o);

  // R1
  done_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> $past(addr_valid_o && addr_ready_i));

  // R5
  irq_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_irq_o && frac_irq_o));

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  // R11
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!addr_valid_o && !desc_rd_o));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .desc_rd_o    (desc_rd_o),
  .done_irq_o   (done_irq_o),
  .frac_irq_o   (frac_irq_o),
  .err_o        (err_o)
);

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WD_CYCLES = 100000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_sel_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic          start_i = 1'b0;
  logic          busy_o, addr_valid_o, desc_rd_o, done_irq_o, frac_irq_o, err_o;
  logic [AW-1:0] addr_o, desc_addr_o;
  logic          addr_ready_i = 1'b1;
  logic          desc_rvalid_i = 1'b0;
  logic [AW-1:0] desc_rdata_i = '0;
  logic [31:0]   mem [0:63];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_addr_seq #(.AW(AW), .CW(16)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .start_i(start_i), .busy_o(busy_o), .addr_o(addr_o),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i), .desc_rd_o(desc_rd_o),
    .desc_addr_o(desc_addr_o), .desc_rvalid_i(desc_rvalid_i), .desc_rdata_i(desc_rdata_i),
    .done_irq_o(done_irq_o), .frac_irq_o(frac_irq_o), .err_o(err_o)
  );

  // descriptor memory: one-cycle read latency
  always @(posedge clk_i) begin
    desc_rvalid_i <= desc_rd_o;
    desc_rdata_i  <= mem[desc_addr_o[5:0]];
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    reg_we_i = 1'b1;
    reg_sel_i = sel;
    reg_wdata_i = val;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic go();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic take(input logic [31:0] exp, input bit exp_done, input bit exp_frac,
                      input string tag);
    int w = 0;
    while (!addr_valid_o && w < 200) begin
      tick();
      w++;
    end
    chk(addr_o, exp, {tag, " addr"});
    tick();
    chk(32'(done_irq_o), 32'(exp_done), {tag, " done"});
    chk(32'(frac_irq_o), 32'(exp_frac), {tag, " frac"});
  endtask

  // cfg word: flow [2:0], frac [4:3], dim2 [5]
  function automatic logic [31:0] cfgw(input int flow, input int frac, input int dim2);
    return 32'(flow) | (32'(frac) << 3) | (32'(dim2) << 5);
  endfunction

  task automatic setup(input int st, input int ic, input int is, input int oc, input int os,
                       input logic [31:0] cfg, input int link);
    do_reset();
    wr(3'd0, 32'(st));
    wr(3'd1, 32'(ic));
    wr(3'd2, 32'(is));
    wr(3'd3, 32'(oc));
    wr(3'd4, 32'(os));
    wr(3'd5, cfg);
    wr(3'd6, 32'(link));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'(i * 1000);
    // ring at 8 and 16 (R7)
    mem[8] = 32'd16;  mem[9] = 32'd300;
    mem[16] = 32'd8;  mem[17] = 32'd400;
    // array at 32 (R8)
    mem[32] = 32'd500; mem[33] = 32'd600; mem[34] = 32'd700;
    // list at 40 -> 44 (R9)
    mem[40] = 32'd44; mem[41] = 32'd800; mem[42] = 32'd3; mem[43] = cfgw(6, 0, 0);
    mem[44] = 32'd0;  mem[45] = 32'd900; mem[46] = 32'd2; mem[47] = cfgw(0, 0, 0);
    // list with zero length (R11)
    mem[48] = 32'd0;  mem[49] = 32'd1000; mem[50] = 32'd0; mem[51] = cfgw(0, 0, 0);

    do_reset();
    // R12 reset state
    chk(32'(busy_o), 0, "R12 busy");
    chk(32'(addr_valid_o), 0, "R12 valid");
    chk(32'(desc_rd_o), 0, "R12 rd");
    chk(32'(done_irq_o | frac_irq_o), 0, "R12 irq");
    chk(32'(err_o), 0, "R12 err");

    // R1 single linear pass
    setup(100, 5, 4, 0, 0, cfgw(0, 0, 0), 0);
    go();
    for (int k = 0; k < 5; k++) take(32'(100 + 4 * k), k == 4, 1'b0, "R1");
    chk(32'(busy_o), 0, "R1 idle busy");
    chk(32'(addr_valid_o), 0, "R1 idle valid");

    // R2 stride sweep
    for (int s = -3; s <= 3; s++) begin
      setup(1000, 4, s, 0, 0, cfgw(0, 0, 0), 0);
      go();
      for (int k = 0; k < 4; k++) take(32'(1000 + k * s), k == 3, 1'b0, "R2");
    end

    // R3 stall
    setup(200, 3, 1, 0, 0, cfgw(0, 0, 0), 0);
    addr_ready_i = 1'b0;
    go();
    tick();
    for (int i = 0; i < 3; i++) begin
      chk(32'(addr_valid_o), 1, "R3 valid held");
      chk(addr_o, 32'd200, "R3 addr held");
      tick();
    end
    addr_ready_i = 1'b1;
    for (int k = 0; k < 3; k++) take(32'(200 + k), k == 2, 1'b0, "R3");

    // R4 auto restart
    setup(50, 3, 2, 0, 0, cfgw(1, 0, 0), 0);
    go();
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 3; k++) take(32'(50 + 2 * k), k == 2, 1'b0, "R4");

    // R5 circular with fraction off/half/quarter
    for (int m = 0; m < 3; m++) begin
      int q;
      q = (m == 0) ? 0 : (8 >> m);
      setup(20, 8, 1, 0, 0, cfgw(2, m, 0), 0);
      go();
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 8; k++)
          take(32'(20 + k), k == 7, (q != 0) && ((k + 1) % q == 0) && (k != 7), "R5");
    end

    // R6 2D, several outer strides
    for (int os = -5; os <= 10; os += 15) begin
      logic [31:0] a;
      setup(0, 3, 1, 2, os, cfgw(0, 0, 1), 0);
      go();
      a = 0;
      for (int o = 0; o < 2; o++)
        for (int i = 0; i < 3; i++) begin
          take(a, (o == 1) && (i == 2), 1'b0, "R6");
          a = (i == 2) ? a + 32'(os) : a + 32'd1;
        end
    end

    // R7 ring of two-word descriptors, R10 fetch quiet
    setup(0, 2, 1, 0, 0, cfgw(4, 0, 0), 8);
    go();
    chk(32'(desc_rd_o), 1, "R10 rd");
    chk(desc_addr_o, 32'd8, "R10 rd addr");
    chk(32'(addr_valid_o), 0, "R10 quiet");
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 2; k++)
        take(32'(((p % 2) == 0 ? 300 : 400) + k), k == 1, 1'b0, "R7");

    // R8 one-word array
    setup(0, 2, 3, 0, 0, cfgw(5, 0, 0), 32);
    go();
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 2; k++) take(32'(500 + 100 * p + 3 * k), k == 1, 1'b0, "R8");

    // R9 four-word list
    setup(0, 7, 1, 0, 0, cfgw(6, 0, 0), 40);
    go();
    for (int k = 0; k < 3; k++) take(32'(800 + k), k == 2, 1'b0, "R9");
    for (int k = 0; k < 2; k++) take(32'(900 + k), k == 1, 1'b0, "R9");
    chk(32'(busy_o), 0, "R9 end busy");

    // R11 zero length in descriptor
    setup(0, 4, 1, 0, 0, cfgw(6, 0, 0), 48);
    go();
    repeat (12) begin
      chk(32'(addr_valid_o), 0, "R11 no addr");
      tick();
    end
    chk(32'(err_o), 1, "R11 err desc");
    chk(32'(busy_o), 0, "R11 halted");

    // R11 zero register count, reserved flow, then clear by start
    setup(10, 0, 1, 0, 0, cfgw(0, 0, 0), 0);
    go();
    tick();
    tick();
    chk(32'(err_o), 1, "R11 err count");
    wr(3'd1, 32'd2);
    wr(3'd5, cfgw(3, 0, 0));
    go();
    tick();
    chk(32'(err_o), 1, "R11 err flow");
    chk(32'(busy_o), 0, "R11 flow idle");
    wr(3'd5, cfgw(0, 0, 0));
    go();
    chk(32'(err_o), 0, "R11 cleared");
    for (int k = 0; k < 2; k++) take(32'(10 + k), k == 1, 1'b0, "R11 run");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule